// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Status Flags

This block is the combinational arithmetic core of a small multi-cycle processor. It takes two 16-bit operands and a 4-bit operation code, and produces a 16-bit result. It also produces a negative flag and a zero flag, which go back to the sequencing controller. The controller compares two registers by subtracting them and testing the zero flag.

The same unit serves every part of the instruction cycle. During fetch it adds one to the program counter. For loads and stores it adds a base register to an offset to form the data address. For register-to-register instructions it applies whichever of the five operations the function field selects. The unit has no state, no clock and no registers. Operand steering and result capture belong to the surrounding datapath.

Top module: `alu16`

## Requirements
- R1: With operation code 0 (add), `result` equals `opa + opb` modulo 2^16, and no overflow indication exists.
- R2: With operation code 1 (subtract), `result` equals `opa - opb` modulo 2^16.
- R3: With operation code 2, `result` is the bitwise AND of the operands.
- R4: With operation code 3, `result` is the bitwise OR of the operands.
- R5: With operation code 4 (set-less-than), `result` is 16'h0001 when `opa` is less than `opb` as two's-complement signed numbers, and 16'h0000 otherwise. Bits 15..1 are always zero for this code.
- R6: Operation codes 5 through 15 produce a `result` of 16'h0000.
- R7: `zero_flag` is 1 exactly when all 16 bits of `result` are 0.
- R8: `neg_flag` always equals bit 15 of `result`.
- R9: Adding 16'h0001 to a program-counter value with code 0 yields the next address. 16'hFFFF wraps to 16'h0000 with `zero_flag` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand (register A, PC or base) |
| opb | input | 16 | Second operand (register B, constant or offset) |
| op_sel | input | 4 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 signed set-less-than |
| result | output | 16 | Operation result |
| neg_flag | output | 1 | Copy of result bit 15 |
| zero_flag | output | 1 | High when result is all zeros |

## Verification
Every output is combinational, so the result and both flags are due in the same cycle as the operands and code that produce them, zero clock edges later. The bench applies each stimulus on the falling clock edge. It samples two nanoseconds later, well before the next rising edge, so each sample sees only the stimulus just applied. Random vectors cover all sixteen codes. Directed vectors cover the signed-compare boundaries, wraparound in both directions and the program-counter increment.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned OP_W   = 4;

    localparam logic [OP_W-1:0] OP_ADD = 4'd0;
    localparam logic [OP_W-1:0] OP_SUB = 4'd1;
    localparam logic [OP_W-1:0] OP_AND = 4'd2;
    localparam logic [OP_W-1:0] OP_OR  = 4'd3;
    localparam logic [OP_W-1:0] OP_SLT = 4'd4;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         less
);
    localparam int unsigned XW = W + 1;

    logic [XW-1:0] a_x;
    logic [XW-1:0] b_x;
    logic [XW-1:0] b_inv;
    logic [XW-1:0] total;

    always_comb begin
        a_x   = {a[W-1], a};
        b_x   = {b[W-1], b};
        b_inv = b_x ^ {XW{sub_en}};
        total = a_x + b_inv + XW'(sub_en);
        sum   = total[W-1:0];
        less  = total[XW-1];
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_o[i] = a[i] & b[i];
        assign or_o[i]  = a[i] | b[i];
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] res,
    output logic         neg,
    output logic         zero
);
    assign neg  = res[W-1];
    assign zero = ~|res;
endmodule

// File: rtl/alu16.sv
module alu16
    import alu16_pkg::*;
(
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [OP_W-1:0]   op_sel,
    output logic [DATA_W-1:0] result,
    output logic              neg_flag,
    output logic              zero_flag
);
    logic              sub_en;
    logic [DATA_W-1:0] sum_w;
    logic              less_w;
    logic [DATA_W-1:0] and_w;
    logic [DATA_W-1:0] or_w;

    assign sub_en = (op_sel != OP_ADD);

    alu16_arith #(.W(DATA_W)) u_arith (
        .a(opa), .b(opb), .sub_en(sub_en), .sum(sum_w), .less(less_w)
    );

    alu16_logic #(.W(DATA_W)) u_logic (
        .a(opa), .b(opb), .and_o(and_w), .or_o(or_w)
    );

    always_comb begin
        unique case (op_sel)
            OP_ADD:  result = sum_w;
            OP_SUB:  result = sum_w;
            OP_AND:  result = and_w;
            OP_OR:   result = or_w;
            OP_SLT:  result = {{(DATA_W-1){1'b0}}, less_w};
            default: result = '0;
        endcase
    end

    alu16_flags #(.W(DATA_W)) u_flags (
        .res(result), .neg(neg_flag), .zero(zero_flag)
    );

    always_comb begin
        if (op_sel == OP_ADD)
            a_r1_add_inverse: assert (DATA_W'(result - opb) == opa);
        if (op_sel == OP_SUB)
            a_r2_sub_inverse: assert (DATA_W'(result + opb) == opa);
        if (op_sel == OP_AND)
            a_r3_and_subset: assert ((result & ~opb) == '0);
        if (op_sel == OP_OR)
            a_r4_or_superset: assert ((result & opa) == opa);
        if (op_sel == OP_SLT)
            a_r5_slt_narrow: assert (result[DATA_W-1:1] == '0);
        if (op_sel > OP_SLT)
            a_r6_unused_zero: assert (result == '0);
        a_r7_zero_flag: assert (zero_flag == (result == '0));
        a_r8_neg_flag: assert (neg_flag == result[DATA_W-1]);
    end
endmodule

// File: tb/alu16_tb.sv
module alu16_tb;
    logic        clk = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [3:0]  op_sel = '0;
    logic [15:0] result;
    logic        neg_flag;
    logic        zero_flag;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu16 u_dut (
        .opa(opa), .opb(opb), .op_sel(op_sel),
        .result(result), .neg_flag(neg_flag), .zero_flag(zero_flag)
    );

    function automatic logic [15:0] ref_res(input logic [3:0] op,
                                            input logic [15:0] a,
                                            input logic [15:0] b);
        case (op)
            4'd0: return 16'(a + b);
            4'd1: return 16'(a - b);
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
            default: return 16'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                         input string req);
        logic [15:0] e;
        @(negedge clk);
        op_sel = op; opa = a; opb = b;
        #2;
        e = ref_res(op, a, b);
        check(req, result, e);
        check("R7", 16'(zero_flag), 16'(e == 16'd0));
        check("R8", 16'(neg_flag), 16'(e[15]));
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // Initial state: all-zero inputs give zero result with Z set (R7)
        apply(4'd0, 16'h0000, 16'h0000, "R1");
        // R1 wrap and R9 program-counter increment
        apply(4'd0, 16'h8000, 16'h8000, "R1");
        apply(4'd0, 16'h0041, 16'h0001, "R9");
        apply(4'd0, 16'hFFFF, 16'h0001, "R9");
        // R2 wrap in both directions
        apply(4'd1, 16'h0000, 16'h0001, "R2");
        apply(4'd1, 16'h8000, 16'h0001, "R2");
        apply(4'd1, 16'h1234, 16'h1234, "R2");
        // R3 and R4 patterns
        apply(4'd2, 16'hF0F0, 16'h3C3C, "R3");
        apply(4'd3, 16'hF0F0, 16'h0F0F, "R4");
        // R5 signed boundaries
        apply(4'd4, 16'h7FFF, 16'h8000, "R5");
        apply(4'd4, 16'h8000, 16'h7FFF, "R5");
        apply(4'd4, 16'hFFFF, 16'h0000, "R5");
        apply(4'd4, 16'h0000, 16'hFFFF, "R5");
        apply(4'd4, 16'h5555, 16'h5555, "R5");
        // R6 unused codes with nonzero operands
        for (int k = 5; k < 16; k++) apply(4'(k), 16'hFFFF, 16'h1234, "R6");
        // Random mix across every code
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            apply(op, 16'($urandom), 16'($urandom), req_of(op));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule